// File: doc/BRIEF.md
# Clock Health Status Monitor

This block supervises the timing inputs of a PCM voice port. It judges whether the bit clock runs fast enough and whether the frame sync is present. It also checks that each frame holds a legal number of bit clocks. It gathers these judgements, an external PLL lock flag and an external memory-clear done flag into one 8-bit status register.

The low five bits show the live state and cannot be written. The top three bits are sticky fault flags. Each one sets when its health condition goes from good to bad, and it stays set until software writes a 1 to that bit. Software therefore sees a dropout even after the clock has recovered.

All three external clock-like inputs pass through two-flop synchronisers before the block looks for edges. Every measurement runs in the system clock domain. Window length, rate threshold, frame-sync timeout and the legal frame-length range are all parameters.

Top module: `clk_health_status`

## Requirements
- R1: After a synchronous reset, the status register reads 0x00.
- R2: A read at address STATUS_ADDR (default 3) returns the status bits in this order: bit 7 PLL-lock fault, bit 6 bit-clock fault, bit 5 frame-sync fault, bit 4 memory-clear done (live copy of `mem_clr_done`), bit 3 PLL locked (synchronised `pll_lock`), bit 2 frame ratio legal, bit 1 bit-clock rate good, bit 0 frame sync present. A read at any other address returns 0x00.
- R3: The bit-clock rate bit is 1 when the last completed window of WINDOW_CYC system cycles (default 256) held at least MIN_PCLK_EDGES rising edges of `pclk` (default 16), and 0 otherwise. With the defaults, a bit-clock period of exactly 16 system cycles is still good.
- R4: The frame-sync present bit sets on a rising edge of `fsync`. It clears after FS_TIMEOUT system cycles (default 4096) pass with no such edge.
- R5: The frame ratio bit is set when the most recent frame held a legal number of bit-clock rising edges. A frame is the span between two consecutive `fsync` rising edges. A count is legal when it equals 2^k for MIN_LOG2 ≤ k ≤ MAX_LOG2 (default 16 to 256). For example, 24 is not legal. The bit is 0 until two frame edges have been seen, and it clears on a frame-sync timeout.
- R6: The PLL-lock fault (bit 7) sets when the synchronised `pll_lock` goes from 1 to 0.
- R7: The bit-clock fault (bit 6) sets when the rate-good bit goes from 1 to 0.
- R8: The frame-sync fault (bit 5) sets when the AND of frame-sync present and frame ratio legal goes from 1 to 0.
- R9: A write to STATUS_ADDR with a 1 in bit 7, 6 or 5 clears that fault. A 0 in a fault position leaves that fault unchanged. Bits 4..0 ignore writes. A write to any other address has no effect.
- R10: If a fault's set event and a write-1 clear of the same fault occur in the same cycle, the fault ends up set.
- R11: A fault stays set after its health condition returns to good, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pclk | input | 1 | PCM bit clock, asynchronous |
| fsync | input | 1 | PCM frame sync, asynchronous |
| pll_lock | input | 1 | External PLL lock flag, asynchronous |
| mem_clr_done | input | 1 | Memory-clear completion flag |
| addr | input | ADDR_W (4) | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |

## Verification
A wrong edge detector or a wrong prior-health register shows up as a fault bit. It either sets with no loss of health, or it stays clear after a loss. This appears on `rdata` two to three cycles after the synchronised input changes. A wrong rate counter or threshold shows up at the end of the next measurement window, at most 2×WINDOW_CYC cycles after the clock changes, as a wrong bit 1 and a spurious or missing bit 6. A wrong frame counter or legality decode shows up at the second frame edge after the change, as a wrong bit 2 and bit 5. The same-cycle set-and-clear case is driven on an exact cycle, so a clear that wins over the set reads back as bit 7 low.

// File: rtl/clk_health_pkg.sv
// Shared status layout for the clock health monitor.
// Assumes a single 8-bit status register; bit order is fixed by software.
package clk_health_pkg;
    typedef struct packed {
        logic pll_fault;   // bit 7
        logic pclk_fault;  // bit 6
        logic fs_fault;    // bit 5
        logic mem_done;    // bit 4
        logic pll_locked;  // bit 3
        logic ratio_ok;    // bit 2
        logic rate_ok;     // bit 1
        logic fs_present;  // bit 0
    } status_t;

    localparam int NUM_FAULTS = 3;
    localparam int FAULT_LSB  = 5;
endpackage

// File: rtl/cdc_sync2.sv
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes each bit is a level or slow clock; no bus coherency is implied.
module cdc_sync2 #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/pclk_rate_meter.sv
// Counts bit-clock rising edges over a fixed window of system cycles.
// At the close of each window it sets rate_ok when the count reached MIN_EDGES.
// Assumes pclk_s is already synchronised to clk.
module pclk_rate_meter #(
    parameter int WINDOW_CYC = 256,
    parameter int MIN_EDGES  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk_s,
    output logic rate_ok
);
    localparam int WW = $clog2(WINDOW_CYC);
    localparam int EW = $clog2(WINDOW_CYC + 1);

    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;
    logic          pclk_d;
    logic          pclk_rise;
    logic          win_end;
    logic [EW:0]   edge_total;

    assign pclk_rise  = pclk_s & ~pclk_d;
    assign win_end    = (win_cnt == WW'(WINDOW_CYC - 1));
    assign edge_total = {1'b0, edge_cnt} + (EW+1)'(pclk_rise);

    // Window timer, edge counter and verdict at window close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_d   <= 1'b0;
            win_cnt  <= '0;
            edge_cnt <= '0;
            rate_ok  <= 1'b0;
        end else begin
            pclk_d <= pclk_s;
            if (win_end) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                rate_ok  <= (edge_total >= (EW+1)'(MIN_EDGES));
            end else begin
                win_cnt  <= win_cnt + 1'b1;
                edge_cnt <= edge_total[EW-1:0];
            end
        end
    end

    // R3
    rate_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(rate_ok));
endmodule

// File: rtl/fsync_checker.sv
// Tracks frame-sync presence with a timeout and checks the bit-clock count per frame.
// The count between consecutive frame edges is legal when it is a power of two
// between 2^MIN_LOG2 and 2^MAX_LOG2. Assumes synchronised inputs.
module fsync_checker #(
    parameter int FS_TIMEOUT = 4096,
    parameter int MIN_LOG2   = 4,
    parameter int MAX_LOG2   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk_s,
    input  logic fsync_s,
    output logic fs_present,
    output logic ratio_ok
);
    localparam int MAXF   = 1 << MAX_LOG2;
    localparam int CW     = $clog2(MAXF + 2);
    localparam int TW     = $clog2(FS_TIMEOUT + 1);
    localparam int NLEGAL = MAX_LOG2 - MIN_LOG2 + 1;

    logic          pclk_d, fsync_d;
    logic          pclk_rise, fs_edge;
    logic [CW-1:0] frame_cnt;
    logic [CW:0]   frame_total;
    logic [TW-1:0] gap_cnt;
    logic          timeout;
    logic          seen_edge;
    logic [NLEGAL-1:0] legal_hit;

    assign pclk_rise   = pclk_s & ~pclk_d;
    assign fs_edge     = fsync_s & ~fsync_d;
    assign frame_total = {1'b0, frame_cnt} + (CW+1)'(pclk_rise);
    assign timeout     = !fs_edge && (gap_cnt == TW'(FS_TIMEOUT - 1));

    // One comparator per legal frame length.
    for (genvar k = 0; k < NLEGAL; k++) begin : g_legal
        assign legal_hit[k] = (frame_total == (CW+1)'(1 << (MIN_LOG2 + k)));
    end

    // Edge history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pclk_d  <= 1'b0;
            fsync_d <= 1'b0;
        end else begin
            pclk_d  <= pclk_s;
            fsync_d <= fsync_s;
        end
    end

    // Bit-clock count within the current frame, saturating above the legal range.
    always_ff @(posedge clk) begin
        if (!rst_n || fs_edge) begin
            frame_cnt <= '0;
        end else if (frame_total <= (CW+1)'(MAXF + 1)) begin
            frame_cnt <= frame_total[CW-1:0];
        end
    end

    // Gap timer, presence flag and ratio verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt    <= '0;
            fs_present <= 1'b0;
            seen_edge  <= 1'b0;
            ratio_ok   <= 1'b0;
        end else if (fs_edge) begin
            gap_cnt    <= '0;
            fs_present <= 1'b1;
            seen_edge  <= 1'b1;
            ratio_ok   <= seen_edge && (|legal_hit);
        end else begin
            if (gap_cnt != TW'(FS_TIMEOUT)) gap_cnt <= gap_cnt + 1'b1;
            if (timeout) begin
                fs_present <= 1'b0;
                seen_edge  <= 1'b0;
                ratio_ok   <= 1'b0;
            end
        end
    end

    // R4
    fs_edge_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_edge |=> fs_present);
    // R5
    ratio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_edge && !timeout) |=> $stable(ratio_ok));
endmodule

// File: rtl/clk_health_status.sv
// Status register for PCM clock health: live validity bits and sticky faults.
// Faults set on a good-to-bad change of their health condition and clear on write-1.
// A set event in the same cycle as a clear wins. Reads are combinational on addr.
module clk_health_status
    import clk_health_pkg::*;
#(
    parameter int              ADDR_W         = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR  = 4'h3,
    parameter int              WINDOW_CYC     = 256,
    parameter int              MIN_PCLK_EDGES = 16,
    parameter int              FS_TIMEOUT     = 4096,
    parameter int              MIN_LOG2       = 4,
    parameter int              MAX_LOG2       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk,
    input  logic              fsync,
    input  logic              pll_lock,
    input  logic              mem_clr_done,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [2:0]            sync_q;
    logic                  pclk_s, fsync_s, lock_s;
    logic                  rate_ok, fs_present, ratio_ok;
    logic [NUM_FAULTS-1:0] health, health_d, fall, fault_q, clr;
    logic                  wr_hit;
    status_t               status;

    cdc_sync2 #(.WIDTH(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pll_lock, fsync, pclk}),
        .sync_out (sync_q)
    );
    assign {lock_s, fsync_s, pclk_s} = sync_q;

    pclk_rate_meter #(.WINDOW_CYC(WINDOW_CYC), .MIN_EDGES(MIN_PCLK_EDGES)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .pclk_s  (pclk_s),
        .rate_ok (rate_ok)
    );

    fsync_checker #(.FS_TIMEOUT(FS_TIMEOUT), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_fs (
        .clk        (clk),
        .rst_n      (rst_n),
        .pclk_s     (pclk_s),
        .fsync_s    (fsync_s),
        .fs_present (fs_present),
        .ratio_ok   (ratio_ok)
    );

    // Fault index 2: PLL lock, 1: bit clock rate, 0: frame sync health.
    assign health = {lock_s, rate_ok, fs_present & ratio_ok};
    assign fall   = health_d & ~health;
    assign wr_hit = wr_en && (addr == STATUS_ADDR);
    assign clr    = wr_hit ? wdata[FAULT_LSB +: NUM_FAULTS] : '0;

    // Previous health, used to find good-to-bad changes.
    always_ff @(posedge clk) begin
        if (!rst_n) health_d <= '0;
        else        health_d <= health;
    end

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_fault
        // Sticky fault: set wins over write-1 clear.
        always_ff @(posedge clk) begin
            if (!rst_n)       fault_q[i] <= 1'b0;
            else if (fall[i]) fault_q[i] <= 1'b1;
            else if (clr[i])  fault_q[i] <= 1'b0;
        end

        // R6 R7 R8 R10
        fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> fault_q[i]);
        // R9 R11
        fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_q[i] && !(wr_hit && wdata[FAULT_LSB + i])) |=> fault_q[i]);
        // R9
        fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && wdata[FAULT_LSB + i] && !fall[i]) |=> !fault_q[i]);
    end

    // Assemble the status word.
    always_comb begin
        status.pll_fault  = fault_q[2];
        status.pclk_fault = fault_q[1];
        status.fs_fault   = fault_q[0];
        status.mem_done   = mem_clr_done;
        status.pll_locked = lock_s;
        status.ratio_ok   = ratio_ok;
        status.rate_ok    = rate_ok;
        status.fs_present = fs_present;
    end

    assign rdata = (addr == STATUS_ADDR) ? status : 8'h00;
endmodule

// File: tb/clk_health_status_test.sv
// Scoreboard bench: the driver queues expected reads, the monitor compares them.
module clk_health_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pclk = 1'b0, fsync = 1'b0, pll_lock = 1'b1, mem_clr_done = 1'b0;
    logic [3:0] addr = 4'h3;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int  checks = 0, fails = 0;
    int  half = 2, frame_len = 16, idx = 0;
    bit  clk_run = 1'b1;
    bit  done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       sample_ev;

    clk_health_status uut (
        .clk(clk), .rst_n(rst_n), .pclk(pclk), .fsync(fsync), .pll_lock(pll_lock),
        .mem_clr_done(mem_clr_done), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    // Bit clock and frame sync generator; frame edges fall in the bit-clock low half.
    initial begin
        forever begin
            if (!clk_run) @(negedge clk);
            else begin
                pclk = 1'b1;
                repeat (half) @(negedge clk);
                pclk  = 1'b0;
                fsync = (idx == 0);
                repeat (half) @(negedge clk);
                idx = (idx >= frame_len - 1) ? 0 : idx + 1;
            end
        end
    end

    // Monitor: pops one expected item per request and compares rdata.
    initial begin
        forever begin
            @(sample_ev);
            @(posedge clk); #1;
            checks++;
            if (rdata !== exp_q[0]) begin
                fails++;
                $display("FAIL %s: rdata=%02h expected=%02h", tag_q[0], rdata, exp_q[0]);
            end
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic expect_read(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> sample_ev;
        @(negedge clk);
        @(negedge clk);
        addr = 4'h3;
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'h3;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run=timeout expected=completion");
            report();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        expect_read(4'h3, 8'h00, "R1 reset value");
        rst_n = 1'b1;

        settle(1500);
        expect_read(4'h3, 8'h0F, "R2 R3 R4 R5 healthy clocks");
        expect_read(4'h5, 8'h00, "R2 other address reads zero");
        mem_clr_done = 1'b1;
        expect_read(4'h3, 8'h1F, "R2 memory-clear done bit");

        frame_len = 256; settle(3500);
        expect_read(4'h3, 8'h1F, "R5 frame of 256 is legal");

        frame_len = 24; settle(1500);
        expect_read(4'h3, 8'h3B, "R5 R8 frame of 24 illegal, fault set");
        reg_write(4'h3, 8'h00);
        reg_write(4'h3, 8'h1F);
        reg_write(4'h6, 8'hFF);
        expect_read(4'h3, 8'h3B, "R9 zero, read-only and other-address writes ignored");
        reg_write(4'h3, 8'h20);
        expect_read(4'h3, 8'h1B, "R9 write-1 clears frame fault");

        frame_len = 16; settle(1500);
        expect_read(4'h3, 8'h1F, "R5 frame of 16 restored");

        half = 8; settle(2000);
        expect_read(4'h3, 8'h1F, "R3 period 16 at threshold still good");
        half = 9; settle(2000);
        expect_read(4'h3, 8'h5D, "R3 R7 period 18 below threshold, fault set");
        half = 2; settle(2000);
        expect_read(4'h3, 8'h5F, "R11 bit-clock fault stays after recovery");
        reg_write(4'h3, 8'h40);
        expect_read(4'h3, 8'h1F, "R9 bit-clock fault cleared");

        // Lock drop timed so the clear strobe meets the set event on the same edge.
        @(negedge clk); pll_lock = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = 4'h3; wdata = 8'h80; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        expect_read(4'h3, 8'h97, "R6 R10 lock fault set wins over clear");
        reg_write(4'h3, 8'h80);
        expect_read(4'h3, 8'h17, "R9 lock fault cleared");
        pll_lock = 1'b1; settle(10);
        expect_read(4'h3, 8'h1F, "R6 relock sets no fault");

        clk_run = 1'b0; settle(6000);
        expect_read(4'h3, 8'h78, "R4 R7 R8 clocks stopped");
        clk_run = 1'b1; settle(3000);
        expect_read(4'h3, 8'h7F, "R4 R11 clocks back, faults latched");
        reg_write(4'h3, 8'h60);
        expect_read(4'h3, 8'h1F, "R9 both faults cleared");

        done = 1'b1;
        report();
    end
endmodule